// File: doc/BRIEF.md
# Dual Peripheral Clock-Enable Divider

This block derives two clock-enable streams, a fast one and a slow one, from the system clock, so that peripherals can run at a reduced rate without a second clock domain. Each stream has its own 3-bit divide code in a 16-bit control word. A code of zero passes the system rate straight through. Any other code N divides by 2N, which gives the ratios 2, 4, 6, 8, 10, 12 and 14. Each stream drives a one-cycle enable pulse, once per output period, and a 50%-duty level that inverts every half period.

Software reaches the two control words over a small register port: a select bit picks the word, a write strobe loads it, and read data returns it combinationally. Writes are taken only while a protection-unlock input is high. A new code waits for the current output period to end, so a peripheral never sees a shortened period.

Top module: `clk_prescaler_dual`

## Requirements
- R1: After a synchronous reset, the fast word reads 0x0001 (divide by 2) and the slow word reads 0x0002 (divide by 4). Both enables and both toggle levels are 0.
- R2: Bits 15:3 of each word always read 0. Writing ones to them has no effect.
- R3: A write with `unlock` low leaves the selected word unchanged, and the output rate does not change.
- R4: `rdata` shows the fast word when `sel`=0 and the slow word when `sel`=1, in the same cycle.
- R5: With a nonzero code N, the enable is high for exactly one cycle in every 2N cycles.
- R6: With a nonzero code N, the toggle level is high for exactly N cycles of each 2N-cycle period.
- R7: With code 0, the enable is high every cycle and the toggle level is held high.
- R8: A code written partway through an output period takes effect only when that period ends. The period in progress completes at its old length.
- R9: The fast and slow channels divide independently. Each follows only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock | input | 1 | Write protection released when high |
| we | input | 1 | Register write strobe |
| sel | input | 1 | Word select: 0 fast, 1 slow |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected word |
| fast_en | output | 1 | Fast channel enable pulse |
| fast_tog | output | 1 | Fast channel 50% toggle level |
| slow_en | output | 1 | Slow channel enable pulse |
| slow_tog | output | 1 | Slow channel 50% toggle level |

## Verification
The bench sweeps all eight codes on both channels at once, giving each channel a different code. For every code it measures the pulse-to-pulse distance and the toggle high time against 2N and N, so an off-by-one terminal count or a missing factor of two shows up as a wrong period. Bypass gets its own expected values: a design that kept toggling or pulsing at code 0 would show a period other than one cycle. A code change is made three cycles after a pulse while dividing by 14. A design that reloads at once would cut that period short of 14. Locked writes and writes to the reserved bits are read back, so a design that skipped the protection check or stored the upper bits fails.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;
    localparam int DIV_W = 3;
    localparam int REG_W = 16;
    localparam int NUM_CH = 2;
    localparam logic [DIV_W-1:0] FAST_RST = 3'd1;
    localparam logic [DIV_W-1:0] SLOW_RST = 3'd2;

    typedef struct packed {
        logic [DIV_W-1:0] cur;
        logic [DIV_W-1:0] cnt;
        logic             phase;
        logic             tog;
        logic             en;
    } chan_state_t;

    function automatic logic [REG_W-1:0] widen(input logic [DIV_W-1:0] f);
        return {{(REG_W-DIV_W){1'b0}}, f};
    endfunction

    function automatic logic [DIV_W-1:0] reset_code(input int ch);
        return (ch == 0) ? FAST_RST : SLOW_RST;
    endfunction
endpackage

// File: rtl/clkpre_regs.sv
module clkpre_regs
    import clkpre_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   unlock,
    input  logic                   we,
    input  logic                   sel,
    input  logic [REG_W-1:0]       wdata,
    output logic [REG_W-1:0]       rdata,
    output logic [NUM_CH*DIV_W-1:0] codes
);
    logic [DIV_W-1:0] code_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                code_q[g] <= reset_code(g);
            else if (we && unlock && (int'(sel) == g))
                code_q[g] <= wdata[DIV_W-1:0];
        end
        assign codes[g*DIV_W +: DIV_W] = code_q[g];

        // R3: a locked write leaves the word alone
        assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (we && !unlock) |=> $stable(code_q[g]));
    end

    assign rdata = widen(code_q[sel]);

    // R2: reserved bits of the read path stay zero
    always_comb begin
        if (!rst) assert_reserved_zero_R2: assert (rdata[REG_W-1:DIV_W] == '0);
    end
endmodule

// File: rtl/clkpre_channel.sv
module clkpre_channel
    import clkpre_pkg::*;
#(
    parameter logic [DIV_W-1:0] RST_CODE = 3'd1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] code,
    output logic             en,
    output logic             tog
);
    chan_state_t st;
    logic        bypass;
    logic        tc;

    assign bypass = (st.cur == '0);
    assign tc     = (st.cnt == st.cur - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cur   <= RST_CODE;
            st.cnt   <= '0;
            st.phase <= 1'b0;
            st.tog   <= 1'b0;
            st.en    <= 1'b0;
        end else if (bypass) begin
            st.cur   <= code;
            st.cnt   <= '0;
            st.phase <= 1'b0;
            st.tog   <= 1'b1;
            st.en    <= 1'b1;
        end else if (tc) begin
            st.cnt   <= '0;
            st.tog   <= ~st.tog;
            st.phase <= ~st.phase;
            st.en    <= st.phase;
            if (st.phase) st.cur <= code;
        end else begin
            st.cnt   <= st.cnt + 1'b1;
            st.en    <= 1'b0;
        end
    end

    assign en  = st.en;
    assign tog = st.tog;

    // R5: the count stays below the active code while dividing
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        !bypass |-> (st.cnt < st.cur));
    // R5: a pulse in divide mode lasts one cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        (en && !bypass) |=> !en);
    // R7: bypass drives a steady enable and a high level
    assert_bypass_high_R7: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (en && tog));
    // R6: the level holds between terminal counts
    assert_tog_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tc) |=> $stable(tog));
endmodule

// File: rtl/clk_prescaler_dual.sv
module clk_prescaler_dual
    import clkpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             fast_en,
    output logic             fast_tog,
    output logic             slow_en,
    output logic             slow_tog
);
    logic [NUM_CH*DIV_W-1:0] codes;
    logic [NUM_CH-1:0]       en_v;
    logic [NUM_CH-1:0]       tog_v;

    clkpre_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .unlock (unlock),
        .we     (we),
        .sel    (sel),
        .wdata  (wdata),
        .rdata  (rdata),
        .codes  (codes)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        clkpre_channel #(.RST_CODE(reset_code(g))) u_ch (
            .clk  (clk),
            .rst  (rst),
            .code (codes[g*DIV_W +: DIV_W]),
            .en   (en_v[g]),
            .tog  (tog_v[g])
        );
    end

    assign fast_en  = en_v[0];
    assign fast_tog = tog_v[0];
    assign slow_en  = en_v[1];
    assign slow_tog = tog_v[1];
endmodule

// File: tb/tb_clk_prescaler_dual.sv
module tb_clk_prescaler_dual;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unlock = 1'b0;
    logic        we = 1'b0;
    logic        sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        fast_en, fast_tog, slow_en, slow_tog;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    clk_prescaler_dual dut (
        .clk(clk), .rst(rst), .unlock(unlock), .we(we), .sel(sel),
        .wdata(wdata), .rdata(rdata),
        .fast_en(fast_en), .fast_tog(fast_tog),
        .slow_en(slow_en), .slow_tog(slow_tog)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input bit s, input logic [15:0] d, input bit unl);
        sel = s; wdata = d; unlock = unl; we = 1'b1;
        step();
        we = 1'b0; unlock = 1'b0;
    endtask

    task automatic rd(input bit s, output int v);
        sel = s;
        #1;
        v = int'(rdata);
    endtask

    function automatic bit en_of(input bit ch);
        return ch ? slow_en : fast_en;
    endfunction

    function automatic bit tog_of(input bit ch);
        return ch ? slow_tog : fast_tog;
    endfunction

    // Aligns to a pulse, then counts the cycles to the next pulse and the
    // cycles the level is high in between.
    task automatic measure(input bit ch, output int period, output int highs);
        int guard = 0;
        while (!en_of(ch) && guard < 100) begin step(); guard++; end
        period = 0; highs = 0;
        do begin
            highs += int'(tog_of(ch));
            period++;
            step();
        end while (!en_of(ch) && period < 100);
    endtask

    initial begin
        int v, p, h;
        step(); step();
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 fast_en", int'(fast_en), 0);
        check("R1 fast_tog", int'(fast_tog), 0);
        check("R1 slow_en", int'(slow_en), 0);
        check("R1 slow_tog", int'(slow_tog), 0);
        rd(1'b0, v); check("R1/R4 fast word", v, 1);
        rd(1'b1, v); check("R1/R4 slow word", v, 2);
        measure(1'b0, p, h); check("R1 fast default period", p, 2);
        measure(1'b1, p, h); check("R1 slow default period", p, 4);

        // R3: locked write dropped
        wr(1'b0, 16'h0005, 1'b0);
        rd(1'b0, v); check("R3 locked fast word", v, 1);
        wr(1'b1, 16'h0006, 1'b0);
        rd(1'b1, v); check("R3 locked slow word", v, 2);
        repeat (20) step();
        measure(1'b0, p, h); check("R3 fast period unchanged", p, 2);

        // R2: reserved bits
        wr(1'b0, 16'hFFF8, 1'b1);
        rd(1'b0, v); check("R2 reserved write fast", v, 0);
        wr(1'b1, 16'hABCD, 1'b1);
        rd(1'b1, v); check("R2 reserved write slow", v, 5);

        // R5 R6 R7 R9: sweep all codes, channels on different codes
        for (int c = 0; c < 8; c++) begin
            int cf = c;
            int cs = 7 - c;
            wr(1'b0, 16'(cf), 1'b1);
            wr(1'b1, 16'(cs), 1'b1);
            rd(1'b0, v); check("R4 fast readback", v, cf);
            repeat (40) step();
            measure(1'b0, p, h);
            check("R5/R7/R9 fast period", p, (cf == 0) ? 1 : 2 * cf);
            check("R6/R7 fast high", h, (cf == 0) ? 1 : cf);
            measure(1'b1, p, h);
            check("R5/R7/R9 slow period", p, (cs == 0) ? 1 : 2 * cs);
            check("R6/R7 slow high", h, (cs == 0) ? 1 : cs);
        end

        // R8: mid-period change completes the old period
        wr(1'b0, 16'd7, 1'b1);
        repeat (40) step();
        measure(1'b0, p, h);
        check("R8 settle at 14", p, 14);
        p = 0;
        do begin
            step();
            p++;
            if (p == 3) begin sel = 1'b0; wdata = 16'd1; unlock = 1'b1; we = 1'b1; end
            if (p == 4) begin we = 1'b0; unlock = 1'b0; end
        end while (!fast_en && p < 100);
        check("R8 period in progress keeps old length", p, 14);
        measure(1'b0, p, h);
        check("R8 new code after boundary", p, 2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule